// File: doc/BRIEF.md
# Quad Halfword Saturating Adder with Media Trap

This block adds two 64-bit operands as four independent signed 16-bit lanes. Each operand is a pair of 32-bit words. Each word carries two halfwords. A lane sum that leaves the signed 16-bit range is clamped to the nearest limit. Every add records, in a 16-bit media status register, which lanes clamped. It also records whether any lane overflowed, a sticky record that an overflow happened at some point, and a trap-type code.

A media-trap request input turns into a one-cycle exception request only when the trap-type code is nonzero. When the code is zero, the request does nothing. The status register is not changed by the trap, so an exception handler reads the same flags that caused it. Software can wipe the low fourteen status bits with a clear strobe. A per-lane signed compare is also provided. It produces less-than and equal flags and never changes the status register.

All outputs are registered and change on the clock edge that samples the matching strobe.

Top module: `qhs_media_unit`

## Requirements
- R1: Lane k occupies operand and result bits [16k+15:16k]. Lanes 0 and 1 form the second (low) word and lanes 2 and 3 the first (high) word. In-range sums wrap normally (0x1234+0xFFFF=0x1233). `result` updates on the edge that samples `add_valid` high and holds otherwise.
- R2: A positive overflow produces 0x7FFF and sets that lane's saturation flag. A sum that lands exactly on 0x7FFF is not flagged.
- R3: A negative overflow produces 0x8000 and sets that lane's saturation flag. A sum that lands exactly on 0x8000 is not flagged.
- R4: Status layout: bit 0 is the sticky overflow, bit 1 is the overflow, bits 5:2 are the lane saturation flags with bit 2+k for lane k, and bits 14:12 are the trap type. Every other bit reads 0.
- R5: Each add rewrites the saturation flags and the overflow bit (the OR of the flags) from that add alone. The sticky overflow bit is set by any saturating add and stays set until cleared.
- R6: A saturating add sets the trap type to 1. A non-saturating add leaves the trap type unchanged.
- R7: `exc_req` is high for the one cycle after each edge that samples `trap_req` high while the trap type is nonzero. With a zero trap type, `trap_req` produces no pulse.
- R8: A trap request leaves the whole status register unchanged.
- R9: `status_clr` zeroes status bits 13:0. When it coincides with an add, the add's updates are applied on top of the cleared value.
- R10: `cmp_valid` registers per-lane signed a<b into `cmp_lt` and a==b into `cmp_eq` (bit k = lane k), and the status register is untouched.
- R11: While `rst_n` is low, `result`, `status`, `cmp_lt`, `cmp_eq` and `exc_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | Perform a saturating lane add this cycle |
| cmp_valid | input | 1 | Perform a signed lane compare this cycle |
| trap_req | input | 1 | Media-trap request |
| status_clr | input | 1 | Clear status bits 13:0 |
| op_a | input | 64 | First operand (word pair) |
| op_b | input | 64 | Second operand (word pair) |
| result | output | 64 | Registered saturated lane sums |
| cmp_lt | output | 4 | Registered per-lane signed less-than |
| cmp_eq | output | 4 | Registered per-lane equality |
| status | output | 16 | Media status register |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The assertions about status stability under a trap or a compare take it for granted that no add or clear is strobed in the same cycle. The trap-cause check assumes the strobes are sampled only at clock edges. The bench changes every input on the falling edge and keeps each strobe high for exactly one rising edge. It issues trap and compare requests only in cycles with no add or clear, so the premises of those checks hold whenever they are tested. Overlapping clear and add is driven on purpose, and only the R9 ordering is checked against it.

// File: rtl/qhs_pkg.sv
package qhs_pkg;
    // Status register geometry; positions are decoded by software.
    localparam int STAT_W   = 16;
    localparam int AOVF_BIT = 0;
    localparam int OVF_BIT  = 1;
    localparam int SAT_LO   = 2;
    localparam int TT_LO    = 12;
    localparam int TT_W     = 3;
    localparam int CLR_W    = 14;
    // Trap-type code recorded by a saturating add.
    localparam logic [TT_W-1:0] TT_SAT = 3'd1;
endpackage

// File: rtl/qhs_sat_lane.sv
module qhs_sat_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         sat
);
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] wrap;
    logic         pos_ovf;
    logic         neg_ovf;

    always_comb begin
        wrap    = a + b;
        pos_ovf = !a[W-1] && !b[W-1] &&  wrap[W-1];
        neg_ovf =  a[W-1] &&  b[W-1] && !wrap[W-1];
        sat     = pos_ovf || neg_ovf;
        if (pos_ovf)      sum = MAX_V;
        else if (neg_ovf) sum = MIN_V;
        else              sum = wrap;
    end
endmodule

// File: rtl/qhs_cmp_lane.sv
module qhs_cmp_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt,
    output logic         eq
);
    always_comb begin
        lt = $signed(a) < $signed(b);
        eq = (a == b);
    end
endmodule

// File: rtl/qhs_media_unit.sv
module qhs_media_unit
    import qhs_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     add_valid,
    input  logic                     cmp_valid,
    input  logic                     trap_req,
    input  logic                     status_clr,
    input  logic [LANE_W*LANES-1:0]  op_a,
    input  logic [LANE_W*LANES-1:0]  op_b,
    output logic [LANE_W*LANES-1:0]  result,
    output logic [LANES-1:0]         cmp_lt,
    output logic [LANES-1:0]         cmp_eq,
    output logic [STAT_W-1:0]        status,
    output logic                     exc_req
);
    localparam int DATA_W = LANE_W * LANES;
    localparam logic [LANE_W-1:0] MAX_V = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] MIN_V = {1'b1, {(LANE_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [STAT_W-1:0] stat;
        logic [LANES-1:0]  lt;
        logic [LANES-1:0]  eq;
        logic              exc;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] sum_w;
    logic [LANES-1:0]  sat_w;
    logic [LANES-1:0]  lt_w;
    logic [LANES-1:0]  eq_w;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        qhs_sat_lane #(.W(LANE_W)) u_add (
            .a   (op_a[k*LANE_W +: LANE_W]),
            .b   (op_b[k*LANE_W +: LANE_W]),
            .sum (sum_w[k*LANE_W +: LANE_W]),
            .sat (sat_w[k])
        );
        qhs_cmp_lane #(.W(LANE_W)) u_cmp (
            .a  (op_a[k*LANE_W +: LANE_W]),
            .b  (op_b[k*LANE_W +: LANE_W]),
            .lt (lt_w[k]),
            .eq (eq_w[k])
        );

        AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.stat[SAT_LO+k] |->
                (st_q.res[k*LANE_W +: LANE_W] == MAX_V ||
                 st_q.res[k*LANE_W +: LANE_W] == MIN_V)); // R2 R3
    end

    always_comb begin
        st_d     = st_q;
        st_d.exc = trap_req && (st_q.stat[TT_LO +: TT_W] != '0);
        if (status_clr) begin
            st_d.stat[CLR_W-1:0] = '0;
        end
        if (add_valid) begin
            st_d.res                  = sum_w;
            st_d.stat[SAT_LO +: LANES] = sat_w;
            st_d.stat[OVF_BIT]        = |sat_w;
            if (|sat_w) begin
                st_d.stat[AOVF_BIT]       = 1'b1;
                st_d.stat[TT_LO +: TT_W]  = TT_SAT;
            end
        end
        if (cmp_valid) begin
            st_d.lt = lt_w;
            st_d.eq = eq_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result  = st_q.res;
    assign status  = st_q.stat;
    assign cmp_lt  = st_q.lt;
    assign cmp_eq  = st_q.eq;
    assign exc_req = st_q.exc;

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ($past(trap_req) && $past(status[TT_LO +: TT_W]) != '0)); // R7

    AST_TRAP_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !add_valid && !status_clr) |=> $stable(status)); // R8

    AST_CMP_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !add_valid && !status_clr) |=> $stable(status)); // R10

    AST_AOVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[AOVF_BIT]) |-> $past(status_clr)); // R5

    AST_TT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|status[TT_LO +: TT_W]) |-> $past(add_valid)); // R6

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !add_valid) |=> (status[CLR_W-1:0] == '0)); // R9
endmodule

// File: tb/qhs_media_unit_bench.sv
module qhs_media_unit_bench;
    localparam int NV = 5;
    // Vector table: operand A, operand B, expected sums, expected lane flags.
    localparam logic [0:NV-1][63:0] VA = {
        64'h1234_5678_7FFE_7FFE, 64'h8000_8001_0001_0000,
        64'h7FFF_8000_4000_C000, 64'h8000_0000_0000_0000,
        64'h0001_0002_0003_0004};
    localparam logic [0:NV-1][63:0] VB = {
        64'hFFFF_FFFF_0002_0001, 64'hFFFF_8000_FFFF_0000,
        64'h7FFF_8000_4000_C000, 64'hFFFF_0000_0000_0000,
        64'h0010_0020_0030_FFFC};
    localparam logic [0:NV-1][63:0] VR = {
        64'h1233_5677_7FFF_7FFF, 64'h8000_8000_0000_0000,
        64'h7FFF_8000_7FFF_8000, 64'h8000_0000_0000_0000,
        64'h0011_0022_0033_0000};
    localparam logic [0:NV-1][3:0] VS = {4'h2, 4'hC, 4'hE, 4'h8, 4'h0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        add_valid = 1'b0, cmp_valid = 1'b0, trap_req = 1'b0, status_clr = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [63:0] result;
    logic [3:0]  cmp_lt, cmp_eq;
    logic [15:0] status;
    logic        exc_req;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    qhs_media_unit u_qhs_media_unit (
        .clk(clk), .rst_n(rst_n), .add_valid(add_valid), .cmp_valid(cmp_valid),
        .trap_req(trap_req), .status_clr(status_clr), .op_a(op_a), .op_b(op_b),
        .result(result), .cmp_lt(cmp_lt), .cmp_eq(cmp_eq), .status(status),
        .exc_req(exc_req));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edge_sample;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        @(negedge clk);
        add_valid = 0; cmp_valid = 0; trap_req = 0; status_clr = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 result", result, 64'h0);
        check("R11 status", {48'h0, status}, 64'h0);
        check("R11 cmp", {56'h0, cmp_lt, cmp_eq}, 64'h0);
        check("R11 exc", {63'h0, exc_req}, 64'h0);
        @(negedge clk); rst_n = 1;

        // R7: zero trap type, no pulse
        @(negedge clk); trap_req = 1;
        edge_sample();
        check("R7 no pulse with zero type", {63'h0, exc_req}, 64'h0);
        idle();

        for (int i = 0; i < NV; i++) begin
            op_a = VA[i]; op_b = VB[i]; add_valid = 1;
            edge_sample();
            check($sformatf("R1 R2 R3 sum vec%0d", i), result, VR[i]);
            check($sformatf("R4 R5 lane flags vec%0d", i), {60'h0, status[5:2]}, {60'h0, VS[i]});
            check($sformatf("R5 ovf vec%0d", i), {63'h0, status[1]}, {63'h0, |VS[i]});
            idle();
        end
        // Sticky overflow kept, trap type kept after non-saturating add
        check("R4 R5 R6 status after table", {48'h0, status}, 64'h1001);

        // R7 R8: trap with nonzero type
        trap_req = 1;
        edge_sample();
        check("R7 pulse", {63'h0, exc_req}, 64'h1);
        check("R8 status kept", {48'h0, status}, 64'h1001);
        idle();
        edge_sample();
        check("R7 single cycle", {63'h0, exc_req}, 64'h0);

        // R9: clear
        @(negedge clk); status_clr = 1;
        edge_sample();
        check("R9 clear", {48'h0, status}, 64'h0);
        idle();
        trap_req = 1;
        edge_sample();
        check("R7 no pulse after clear", {63'h0, exc_req}, 64'h0);
        idle();

        // R10: compare
        op_a = 64'h1234_5678_7FFE_7FFE; op_b = 64'h1234_5679_7FFD_8000; cmp_valid = 1;
        edge_sample();
        check("R10 lt", {60'h0, cmp_lt}, 64'h4);
        check("R10 eq", {60'h0, cmp_eq}, 64'h8);
        check("R10 status untouched", {48'h0, status}, 64'h0);
        idle();

        // R9: clear coinciding with add
        op_a = VA[0]; op_b = VB[0]; add_valid = 1;
        edge_sample();
        check("R4 R6 saturating status", {48'h0, status}, 64'h100B);
        idle();
        op_a = VA[4]; op_b = VB[4]; add_valid = 1; status_clr = 1;
        edge_sample();
        check("R9 clear plus clean add", {48'h0, status}, 64'h0);
        check("R9 clear plus add result", result, VR[4]);
        idle();
        op_a = VA[3]; op_b = VB[3]; add_valid = 1; status_clr = 1;
        edge_sample();
        check("R9 clear plus saturating add", {48'h0, status}, 64'h1023);
        idle();
        edge_sample();
        check("R1 result holds", result, VR[3]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule